// File: doc/BRIEF.md
# Banked Scratchpad Conflict Arbiter

This block serves one read request from a 32-lane group against an on-chip scratchpad split into 32 banks, each one 32-bit word wide. Every lane brings a byte address and a valid bit. The block finds the bank that each address falls in. It works out which lanes can share a bank access and runs the request as a series of passes. In each pass every bank delivers at most one word.

Lanes that ask for the same word are merged into a single broadcast access. Lanes that ask one bank for different words are spread over separate passes. The number of passes is therefore the largest number of distinct words that any one bank must supply, not the number of lanes involved.

The bank storage is read-only inside this block. Each bank array is preset at reset with a fixed pattern, so every result can be predicted from the address alone. When all active lanes have their data, the block pulses a done flag. The per-lane results stay on the outputs until the next request is accepted.

Top module: `scp_conflict_arbiter`

## Requirements
- R1: A byte address selects bank = addr[6:2] and row = addr[11:7]. The two lowest address bits are ignored. The word with index w = row*32 + bank reads as 32'h5A5A0000 | w.
- R2: Active lanes whose words all lie in distinct banks complete in a single pass. This includes a stride of 33 words, which is a column of a padded 32x33 array.
- R3: Active lanes that hit one bank at different words are served in separate passes. For n passes, done is asserted n+1 clock cycles after the accepting clock edge, so a stride of 32 words costs 32 passes.
- R4: Active lanes that read an identical word are served together in one pass, with no extra pass for the sharing.
- R5: Inactive lanes return zero data and do not add to the pass count.
- R6: A request with no active lanes asserts done in the cycle right after the accepting edge.
- R7: Done is high for exactly one cycle. The per-lane data stays stable after done until the next request is accepted, and it is cleared to zero when that request is accepted.
- R8: A request is accepted only when busy is low. Busy is high from the accepting edge until the done cycle, and a request presented while busy is high has no effect.
- R9: After reset, busy and done are low and every lane's data is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken when busy is low |
| req_active | input | 32 | Per-lane valid bits |
| req_addr | input | 384 | Lane byte addresses, 12 bits each; lane i at bits [12i+11:12i] |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse when all active lanes are served |
| rsp_data | output | 1024 | Lane results, 32 bits each; lane i at bits [32i+31:32i] |

## Verification
Broadcast merging and conflict serialization can fall in the same pass. While one bank hands a single shared word to many lanes, another bank can be working through a queue of different words. The bench provokes this with a split pattern: half the lanes share one word and the other half walk down a single bank by 32-word strides. It judges the result by checking that the pass count equals the serialized bank's depth alone, and that every lane, including the broadcast ones, carries its own expected word.

// File: rtl/scp_pkg.sv
package scp_pkg;

  // Bank word width is fixed at four bytes.
  localparam int WORD_W   = 32;
  localparam int OFFSET_W = 2;
  localparam logic [WORD_W-1:0] PRESET_TAG = 32'h5A5A_0000;

  typedef logic [WORD_W-1:0] word_t;

  // Preset content of the word with global word index widx.
  function automatic word_t preset_word(input int unsigned widx);
    preset_word = PRESET_TAG | word_t'(widx & 32'h0000_FFFF);
  endfunction

endpackage

// File: rtl/scp_bank_ram.sv
module scp_bank_ram
  import scp_pkg::*;
#(
  parameter int BANKS   = 32,
  parameter int ROWS    = 32,
  parameter int BANK_ID = 0,
  localparam int ROW_W  = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [ROW_W-1:0] rd_row,
  output word_t            rd_data
);

  word_t mem [ROWS];
  word_t rd_q;

  // Read-only array, preset at reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) begin
        mem[r] <= preset_word(r * BANKS + BANK_ID);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= mem[rd_row];
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/scp_bank_pick.sv
module scp_bank_pick #(
  parameter int LANES   = 32,
  parameter int BANKS   = 32,
  parameter int ROWS    = 32,
  parameter int BANK_ID = 0,
  localparam int BANK_W = $clog2(BANKS),
  localparam int ROW_W  = $clog2(ROWS)
) (
  input  logic [LANES-1:0]             pending,
  input  logic [LANES-1:0][BANK_W-1:0] lane_bank,
  input  logic [LANES-1:0][ROW_W-1:0]  lane_row,
  output logic [LANES-1:0]             hit,
  output logic                         rd_en,
  output logic [ROW_W-1:0]             rd_row
);

  // Lowest pending lane in this bank chooses the row for this pass.
  always_comb begin
    rd_en  = 1'b0;
    rd_row = '0;
    for (int l = LANES - 1; l >= 0; l--) begin
      if (pending[l] && (lane_bank[l] == BANK_W'(BANK_ID))) begin
        rd_en  = 1'b1;
        rd_row = lane_row[l];
      end
    end
  end

  // Every pending lane that wants the chosen word retires now.
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      hit[l] = rd_en && pending[l] &&
               (lane_bank[l] == BANK_W'(BANK_ID)) &&
               (lane_row[l] == rd_row);
    end
  end

endmodule

// File: rtl/scp_conflict_arbiter.sv
module scp_conflict_arbiter
  import scp_pkg::*;
#(
  parameter int LANES   = 32,
  parameter int BANKS   = 32,
  parameter int ROWS    = 32,
  localparam int BANK_W = $clog2(BANKS),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int ADDR_W = OFFSET_W + BANK_W + ROW_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [LANES-1:0]          req_active,
  input  logic [LANES*ADDR_W-1:0]   req_addr,
  output logic                      busy,
  output logic                      done,
  output logic [LANES*WORD_W-1:0]   rsp_data
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Registered state.
  logic [LANES-1:0][BANK_W-1:0] bank_q;
  logic [LANES-1:0][ROW_W-1:0]  row_q;
  logic [LANES-1:0]             active_q;
  logic [LANES-1:0]             pending_q;
  logic [LANES-1:0]             issued_q;
  logic                         done_q;
  word_t                        data_q [LANES];

  // Next-state signals.
  logic [LANES-1:0][BANK_W-1:0] bank_d;
  logic [LANES-1:0][ROW_W-1:0]  row_d;
  logic [LANES-1:0]             pending_d;
  logic [LANES-1:0]             issued_d;
  logic                         done_d;
  word_t                        data_d [LANES];
  logic                         accept;
  logic                         data_en;
  logic [LANES-1:0]             grant;
  logic [LANES*OFFSET_W-1:0]    unused_offset_bits;

  // Per-bank selection and storage.
  logic [BANKS-1:0][LANES-1:0]  bank_hit;
  logic [BANKS-1:0]             bank_rd_en;
  logic [BANKS-1:0][ROW_W-1:0]  bank_rd_row;
  word_t                        bank_rd_data [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    scp_bank_pick #(
      .LANES(LANES), .BANKS(BANKS), .ROWS(ROWS), .BANK_ID(b)
    ) i_pick (
      .pending   (pending_q),
      .lane_bank (bank_q),
      .lane_row  (row_q),
      .hit       (bank_hit[b]),
      .rd_en     (bank_rd_en[b]),
      .rd_row    (bank_rd_row[b])
    );

    scp_bank_ram #(
      .BANKS(BANKS), .ROWS(ROWS), .BANK_ID(b)
    ) i_ram (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .rd_en   (bank_rd_en[b]),
      .rd_row  (bank_rd_row[b]),
      .rd_data (bank_rd_data[b])
    );
  end

  always_comb begin
    grant = '0;
    for (int b = 0; b < BANKS; b++) grant = grant | bank_hit[b];
  end

  assign busy   = (|pending_q) || (|issued_q);
  assign accept = req_valid && !busy;

  // Address split.
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      bank_d[l] = req_addr[l*ADDR_W + OFFSET_W +: BANK_W];
      row_d[l]  = req_addr[l*ADDR_W + OFFSET_W + BANK_W +: ROW_W];
      unused_offset_bits[l*OFFSET_W +: OFFSET_W] = req_addr[l*ADDR_W +: OFFSET_W];
    end
  end

  // Pass sequencing.
  always_comb begin
    if (accept) begin
      pending_d = req_active;
      issued_d  = '0;
      done_d    = (req_active == '0);
    end else begin
      pending_d = pending_q & ~grant;
      issued_d  = grant;
      done_d    = (|issued_q) && (pending_q == '0);
    end
  end

  // Result capture, one pass behind the bank read.
  always_comb begin
    data_en = accept || (|issued_q);
    for (int l = 0; l < LANES; l++) begin
      if (accept)           data_d[l] = '0;
      else if (issued_q[l]) data_d[l] = bank_rd_data[bank_q[l]];
      else                  data_d[l] = data_q[l];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      bank_q   <= '0;
      row_q    <= '0;
      active_q <= '0;
    end else if (accept) begin
      bank_q   <= bank_d;
      row_q    <= row_d;
      active_q <= req_active;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pending_q <= '0;
      issued_q  <= '0;
      done_q    <= 1'b0;
    end else begin
      pending_q <= pending_d;
      issued_q  <= issued_d;
      done_q    <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      for (int l = 0; l < LANES; l++) data_q[l] <= '0;
    end else if (data_en) begin
      for (int l = 0; l < LANES; l++) data_q[l] <= data_d[l];
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) rsp_data[l*WORD_W +: WORD_W] = data_q[l];
  end
  assign done = done_q;

  // Checks.
  logic [LANES-1:0] nonzero_lane;
  always_comb begin
    for (int l = 0; l < LANES; l++) nonzero_lane[l] = |data_q[l];
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> !done);

  assert_pass_progress_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|pending_q) |=> (((pending_q & ~$past(pending_q)) == '0) &&
                      (pending_q != $past(pending_q))));

  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && req_valid) |=> $stable(active_q));

  assert_inactive_zero_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> ((nonzero_lane & ~active_q) == '0));

  assert_empty_done_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && !busy && (req_active == '0)) |=> done);

endmodule

// File: tb/test_scp_conflict_arbiter.sv
module test_scp_conflict_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 32;
  localparam int ADDR_W = 12;
  localparam int WORDS  = 1024;

  typedef struct packed {
    logic [2:0]  shift;
    logic [5:0]  stride;
    logic [9:0]  base;
    logic        split;
    logic [1:0]  lowb;
    logic [31:0] active;
    logic [5:0]  passes;
  } vec_t;

  localparam int NVEC = 13;
  // word = ((lane >> shift) * stride + base) mod 1024; split: lanes 0..15 read word 5
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 6'd1,  10'd0,    1'b0, 2'd0, 32'hFFFF_FFFF, 6'd1 },  // R2 unit stride
    '{3'd0, 6'd33, 10'd0,    1'b0, 2'd0, 32'hFFFF_FFFF, 6'd1 },  // R2 padded column
    '{3'd0, 6'd32, 10'd0,    1'b0, 2'd0, 32'hFFFF_FFFF, 6'd32},  // R3 unpadded column
    '{3'd0, 6'd2,  10'd0,    1'b0, 2'd0, 32'hFFFF_FFFF, 6'd2 },  // R3 two-way
    '{3'd0, 6'd4,  10'd7,    1'b0, 2'd3, 32'hFFFF_FFFF, 6'd4 },  // R1 offset bits ignored
    '{3'd0, 6'd0,  10'd100,  1'b0, 2'd0, 32'hFFFF_FFFF, 6'd1 },  // R4 full broadcast
    '{3'd1, 6'd32, 10'd0,    1'b0, 2'd0, 32'hFFFF_FFFF, 6'd16},  // R4 pairs share
    '{3'd3, 6'd32, 10'd3,    1'b0, 2'd1, 32'hFFFF_FFFF, 6'd4 },  // R4 groups of eight
    '{3'd0, 6'd32, 10'd0,    1'b0, 2'd0, 32'h0000_00F0, 6'd4 },  // R5 few active
    '{3'd0, 6'd32, 10'd0,    1'b0, 2'd0, 32'hAAAA_AAAA, 6'd16},  // R5 odd lanes
    '{3'd0, 6'd32, 10'd1,    1'b1, 2'd0, 32'hFFFF_FFFF, 6'd16},  // R3/R4 same pass
    '{3'd0, 6'd1,  10'd1000, 1'b0, 2'd2, 32'hFFFF_FFFF, 6'd1 },  // R1 wrap
    '{3'd0, 6'd16, 10'd0,    1'b0, 2'd0, 32'hFFFF_FFFF, 6'd16}   // R3 two banks
  };

  logic                     clk;
  logic                     rst_n;
  logic                     req_valid;
  logic [LANES-1:0]         req_active;
  logic [LANES*ADDR_W-1:0]  req_addr;
  logic                     busy;
  logic                     done;
  logic [LANES*32-1:0]      rsp_data;

  int checks;
  int errors;
  int cycles;

  logic [31:0] exp_data [LANES];

  scp_conflict_arbiter i_scp_conflict_arbiter (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_active (req_active),
    .req_addr   (req_addr),
    .busy       (busy),
    .done       (done),
    .rsp_data   (rsp_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] word_value(input int unsigned w);
    return 32'h5A5A_0000 | w;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // Build addresses and expected data from a vector.
  task automatic load_vec(input vec_t v);
    for (int l = 0; l < LANES; l++) begin
      int unsigned w;
      if (v.split && l < 16) w = 5;
      else w = (((l >> v.shift) * v.stride) + v.base) % WORDS;
      req_addr[l*ADDR_W +: ADDR_W] = {w[9:0], v.lowb};
      req_active[l] = v.active[l];
      exp_data[l] = v.active[l] ? word_value(w) : 32'h0;
    end
  endtask

  // Present a loaded request; returns the cycle count, accept edge counted as 1.
  task automatic run_req(output int lat);
    @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic check_data(input string req);
    int bad;
    int bad_lane;
    bad = 0;
    bad_lane = 0;
    for (int l = 0; l < LANES; l++) begin
      if (rsp_data[l*32 +: 32] !== exp_data[l]) begin
        if (bad == 0) bad_lane = l;
        bad++;
      end
    end
    check(bad == 0, req, $sformatf("lane %0d data", bad_lane),
          rsp_data[bad_lane*32 +: 32], exp_data[bad_lane]);
  endtask

  initial begin
    int lat;
    checks = 0;
    errors = 0;
    cycles = 0;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_active = '0;
    req_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 reset state
    check(busy == 1'b0, "R9", "busy after reset", busy, 0);
    check(done == 1'b0, "R9", "done after reset", done, 0);
    check(rsp_data == '0, "R9", "data after reset", rsp_data[31:0], 0);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      load_vec(VECS[i]);
      run_req(lat);
      check(lat == VECS[i].passes + 2, "R3",
            $sformatf("vector %0d latency", i), lat, VECS[i].passes + 2);
      check_data($sformatf("R1 vector %0d", i));
      @(negedge clk);
      check(done == 1'b0, "R7", $sformatf("vector %0d done width", i), done, 0);
      check_data("R7 hold");
    end

    // R6 empty request clears previous data
    req_active = '0;
    for (int l = 0; l < LANES; l++) exp_data[l] = 32'h0;
    run_req(lat);
    check(lat == 1, "R6", "empty latency", lat, 1);
    check_data("R6");

    // R8 request while busy is ignored
    load_vec(VECS[2]);
    @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(busy == 1'b1, "R8", "busy mid request", busy, 1);
    begin
      logic [LANES*ADDR_W-1:0] keep_addr;
      keep_addr = req_addr;
      for (int l = 0; l < LANES; l++)
        req_addr[l*ADDR_W +: ADDR_W] = {10'(l + 500), 2'd0};
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      req_addr = keep_addr;
    end
    lat = 0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    check(done == 1'b1, "R8", "done reached", done, 1);
    check_data("R8 ignored request");
    @(negedge clk);
    check(busy == 1'b0, "R8", "idle after done", busy, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule